// File: doc/BRIEF.md
# Secondary Test-Port Controller for a Stacked Memory Die Wrapper

This block is a second test access port placed in a host die. It has its own clock, mode-select, data-in, data-out and reset pins. It converts standard test-port sequences into the control set of a core test wrapper that sits on an attached memory die, because that die has no state machine of its own. The block runs the full sixteen-state test-port state machine, decodes a private instruction register, and drives the wrapper's clock, reset, instruction-select, shift, capture and update lines off the die.

The wrapper lines are level enables that travel next to a wrapper clock. That clock is a plain copy of the test clock, with no gating. All enables are registered on the falling clock edge, so the wrapper sees them settled at its next rising edge. None of these lines passes through boundary-scan cells. They therefore keep working while the host's primary test port holds an interconnect-test, clamp or high-impedance instruction, and one scan session can drive the interconnect test on both dies.

A typical session first selects wrapper-instruction access and scans a wrapper instruction, for example the identification register, through the data path with the instruction-select line high. It then selects wrapper-data access and scans the chosen wrapper register with that line low. This is how the die's identity code is read back to check that the die is present and is the correct one.

Top module: `wrap_master_tap`

## Requirements
- R1: `wrck` is at every instant equal to `tck`; no enable is merged into the clock.
- R2: The state machine follows the standard sixteen-state test-port transitions on rising `tck`. `trst_n` low at a rising edge forces Test-Logic-Reset, and so do five rising edges with `tms` high.
- R3: `wrst_n` is low while `trst_n` is low and while the state is Test-Logic-Reset. It goes high at the first falling edge after the machine has left that state.
- R4: The instruction register is 4 bits, shifted in LSB first. Capture-IR loads 4'b0001. Test-Logic-Reset selects 4'b1111. Code 4'b0010 is wrapper-instruction access, code 4'b0011 is wrapper-data access, and every other code acts as bypass.
- R5: Under bypass, a 1-bit register captures 0 in Capture-DR and delays `tdi` by one cycle to `tdo` in Shift-DR. `shift_wr`, `capture_wr`, `update_wr` and `sel_wir` all stay low.
- R6: Under either wrapper access code, `capture_wr`, `shift_wr` and `update_wr` are high exactly while the state is Capture-DR, Shift-DR and Update-DR respectively. Each is registered on falling `tck` and is never high together with another.
- R7: `sel_wir` is high exactly while wrapper-instruction access is the current instruction, and low under wrapper-data access.
- R8: `wsi` carries `tdi`. In Shift-DR under a wrapper access code, `tdo` takes `wso` at each falling edge, so the wrapper's captured bits appear LSB first.
- R9: `tdo_en` is high only during Shift-IR and Shift-DR, changing on falling `tck`. In Shift-IR, `tdo` shows the instruction shift register LSB.
- R10: After the wrapper identification instruction is loaded, a 32-bit wrapper-data scan returns the die's identity code LSB first on `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock of the dedicated port |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | High while serial data out is valid |
| wrck | output | 1 | Wrapper clock, a copy of `tck` |
| wrst_n | output | 1 | Wrapper reset, active low |
| sel_wir | output | 1 | Wrapper instruction-register select |
| shift_wr | output | 1 | Wrapper shift enable |
| capture_wr | output | 1 | Wrapper capture enable |
| update_wr | output | 1 | Wrapper update enable |
| wsi | output | 1 | Wrapper serial input |
| wso | input | 1 | Wrapper serial output |

## Verification
The bench connects a behavioural wrapper that holds a 3-bit instruction register, a 1-bit bypass and a 32-bit identity register. Each scan is checked cycle by cycle against its expected enables and serial output. An instruction scan with a known code tells the captured 0001 apart from stale register contents. A bypass data scan with the pattern 1,1,0,1,0,0,1,0 shows the one-cycle delay and the silent wrapper lines, and an undefined code run through the same scan shows it falls back to bypass. A wrapper-instruction scan followed by a 32-bit wrapper-data scan must reproduce an asymmetric identity code. That separates correct enable timing and select polarity from an off-by-one shift count, a swapped select, or enables that leak across states.

// File: rtl/wm_pkg.sv
// Package wm_pkg
// Shared types for the secondary test-port controller: the sixteen
// test-port states and the decoded instruction class.
package wm_pkg;

    typedef enum logic [3:0] {
        ST_TLR    = 4'd0,
        ST_RTI    = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SHF_DR = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SHF_IR = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_st_e;

    typedef enum logic [1:0] {
        M_BYPASS = 2'd0,
        M_WIR    = 2'd1,
        M_WDR    = 2'd2
    } wm_mode_e;

endpackage

// File: rtl/wm_tap_fsm.sv
// Module wm_tap_fsm
// The sixteen-state test-port state machine, advanced on rising tck.
// Assumes: trst_n is a synchronous active-low reset sampled on rising tck.
module wm_tap_fsm
    import wm_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_e state
);

    tap_st_e nxt;

    // Purpose: standard transition table driven by tms.
    always_comb begin
        nxt = state;
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // Purpose: state register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // R2: high tms holds Test-Logic-Reset
    a_r2_tlr_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR && tms) |=> (state == ST_TLR));

    // R2: Update-DR always leaves to Run-Test/Idle or Select-DR
    a_r2_upd_exit: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_DR) |=> (state == ST_RTI || state == ST_SEL_DR));

endmodule

// File: rtl/wm_ir_decode.sv
// Module wm_ir_decode
// Instruction shift and hold registers plus decode into bypass,
// wrapper-instruction access or wrapper-data access.
// Assumes: state comes from wm_tap_fsm in the same tck domain.
module wm_ir_decode
    import wm_pkg::*;
#(
    parameter int          IR_W     = 4,
    parameter logic [IR_W-1:0] WIR_CODE = 4'b0010,
    parameter logic [IR_W-1:0] WDR_CODE = 4'b0011
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_st_e  state,
    output logic     ir_lsb,
    output wm_mode_e mode
);

    localparam logic [IR_W-1:0] IR_CAPT = {{(IR_W-2){1'b0}}, 2'b01};
    localparam logic [IR_W-1:0] IR_BYP  = {IR_W{1'b1}};

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    // Purpose: instruction shift register, capture then shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= IR_CAPT;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPT;
        else if (state == ST_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Purpose: instruction hold register, loaded on leaving Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_q <= IR_BYP;
        else if (state == ST_TLR)    ir_q <= IR_BYP;
        else if (state == ST_UPD_IR) ir_q <= ir_sr;
    end

    // Purpose: map the held code onto an instruction class.
    always_comb begin
        if (ir_q == WIR_CODE)      mode = M_WIR;
        else if (ir_q == WDR_CODE) mode = M_WDR;
        else                       mode = M_BYPASS;
    end

    assign ir_lsb = ir_sr[0];

    // R4: Test-Logic-Reset returns the decode to bypass
    a_r4_tlr_bypass: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (mode == M_BYPASS));

    // R4: instruction only changes when leaving Update-IR
    a_r4_ir_stable: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));

endmodule

// File: rtl/wm_wrap_drive.sv
// Module wm_wrap_drive
// Bypass bit, and the falling-edge registers that drive the wrapper
// enables, wrapper reset, instruction select and serial output.
// Assumes: state and mode change only on rising tck.
module wm_wrap_drive
    import wm_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_st_e  state,
    input  wm_mode_e mode,
    input  logic     ir_lsb,
    input  logic     wso,
    output logic     tdo,
    output logic     tdo_en,
    output logic     wrst_n,
    output logic     sel_wir,
    output logic     shift_wr,
    output logic     capture_wr,
    output logic     update_wr
);

    logic byp_q;
    logic wrap_on;

    assign wrap_on = (mode != M_BYPASS);

    // Purpose: 1-bit bypass register used when no wrapper access is selected.
    always_ff @(posedge tck) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (state == ST_CAP_DR) byp_q <= 1'b0;
        else if (state == ST_SHF_DR) byp_q <= tdi;
    end

    // Purpose: wrapper enables and select, settled before the next rising edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            shift_wr   <= 1'b0;
            capture_wr <= 1'b0;
            update_wr  <= 1'b0;
            sel_wir    <= 1'b0;
        end else begin
            shift_wr   <= wrap_on && (state == ST_SHF_DR);
            capture_wr <= wrap_on && (state == ST_CAP_DR);
            update_wr  <= wrap_on && (state == ST_UPD_DR);
            sel_wir    <= (mode == M_WIR);
        end
    end

    // Purpose: wrapper reset, low in Test-Logic-Reset, released on a falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) wrst_n <= 1'b0;
        else         wrst_n <= (state != ST_TLR);
    end

    // Purpose: serial output mux and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SHF_DR) || (state == ST_SHF_IR);
            if (state == ST_SHF_IR)      tdo <= ir_lsb;
            else if (state == ST_SHF_DR) tdo <= wrap_on ? wso : byp_q;
        end
    end

    // R6: at most one wrapper enable is active
    a_r6_onehot: assert property (@(negedge tck) disable iff (!trst_n)
        $onehot0({shift_wr, capture_wr, update_wr}));

    // R5: bypass keeps the wrapper lines quiet
    a_r5_bypass_quiet: assert property (@(negedge tck) disable iff (!trst_n)
        (mode == M_BYPASS) |=> (!shift_wr && !capture_wr && !update_wr && !sel_wir));

    // R3: Test-Logic-Reset holds the wrapper in reset
    a_r3_tlr_reset: assert property (@(negedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> !wrst_n);

    // R7: wrapper-instruction access raises the select
    a_r7_sel: assert property (@(negedge tck) disable iff (!trst_n)
        (mode == M_WIR) |=> sel_wir);

    // R9: output enable only in shift states
    a_r9_oe: assert property (@(negedge tck) disable iff (!trst_n)
        (state != ST_SHF_DR && state != ST_SHF_IR) |=> !tdo_en);

endmodule

// File: rtl/wrap_master_tap.sv
// Module wrap_master_tap
// Secondary test port that masters a core test wrapper on an attached die.
// Assumes: wrapper samples its enables and wsi on rising wrck and drives
// wso from its shift register; wrck is a plain copy of tck.
module wrap_master_tap
    import wm_pkg::*;
#(
    parameter int          IR_W     = 4,
    parameter logic [IR_W-1:0] WIR_CODE = 4'b0010,
    parameter logic [IR_W-1:0] WDR_CODE = 4'b0011
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic wrck,
    output logic wrst_n,
    output logic sel_wir,
    output logic shift_wr,
    output logic capture_wr,
    output logic update_wr,
    output logic wsi,
    input  logic wso
);

    tap_st_e  state;
    wm_mode_e mode;
    logic     ir_lsb;

    // Purpose: clock and serial data leave the die unmodified.
    assign wrck = tck;
    assign wsi  = tdi;

    wm_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    wm_ir_decode #(
        .IR_W     (IR_W),
        .WIR_CODE (WIR_CODE),
        .WDR_CODE (WDR_CODE)
    ) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .ir_lsb (ir_lsb),
        .mode   (mode)
    );

    wm_wrap_drive u_drv (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state      (state),
        .mode       (mode),
        .ir_lsb     (ir_lsb),
        .wso        (wso),
        .tdo        (tdo),
        .tdo_en     (tdo_en),
        .wrst_n     (wrst_n),
        .sel_wir    (sel_wir),
        .shift_wr   (shift_wr),
        .capture_wr (capture_wr),
        .update_wr  (update_wr)
    );

endmodule

// File: tb/sim_wrap_master_tap.sv
module sim_wrap_master_tap;

    localparam logic [31:0] DIE_ID = 32'h1A5C_3E97;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en, wrck, wrst_n, sel_wir, shift_wr, capture_wr, update_wr, wsi, wso;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [31:0] exp;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] act_q[$];

    always #5 tck = ~tck;

    wrap_master_tap u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .wrck(wrck), .wrst_n(wrst_n), .sel_wir(sel_wir), .shift_wr(shift_wr),
        .capture_wr(capture_wr), .update_wr(update_wr), .wsi(wsi), .wso(wso)
    );

    // Behavioural wrapper on the attached die
    logic [2:0]  w_ir;
    logic [31:0] w_sr;
    assign wso = w_sr[0];
    always @(posedge wrck) begin
        if (!wrst_n) begin
            w_ir <= 3'd0;
            w_sr <= 32'd0;
        end else if (capture_wr) begin
            if (sel_wir)          w_sr <= 32'd1;
            else if (w_ir == 3'd1) w_sr <= DIE_ID;
            else                  w_sr <= 32'd0;
        end else if (shift_wr) begin
            if (sel_wir)           w_sr[2:0] <= {wsi, w_sr[2:1]};
            else if (w_ir == 3'd1) w_sr <= {wsi, w_sr[31:1]};
            else                   w_sr[0] <= wsi;
        end else if (update_wr && sel_wir) begin
            w_ir <= w_sr[2:0];
        end
    end

    // Driver side: queue one expectation with its observed value
    task automatic expect_val(string req, logic [31:0] act, logic [31:0] exp);
        exp_t e;
        e.req = req;
        e.exp = exp;
        exp_q.push_back(e);
        act_q.push_back(act);
    endtask

    // Monitor: pop and compare as results appear
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                exp_t        e;
                logic [31:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a !== e.exp) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", e.req, a, e.exp);
                end
            end
        end
    end

    // One test clock: drive after falling edge, sample before rising edge
    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        #2;
        o = tdo;
    endtask

    task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        tick(1, 0, o);
        tick(1, 0, o);
        tick(0, 0, o);
        tick(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], o);
            cap[i] = o;
            expect_val("R9 tdo_en in Shift-IR", {31'd0, tdo_en}, 32'd1);
        end
        tick(1, 0, o);
        tick(0, 0, o);
        tick(0, 0, o);
    endtask

    // Data scan with per-state enable checks; wrap = wrapper lines expected active
    task automatic dr_scan(input int n, input logic [31:0] din, input logic wrap,
                           output logic [31:0] dout);
        logic o;
        dout = '0;
        tick(1, 0, o);
        tick(0, 0, o);
        tick(0, 0, o);
        expect_val("R6 capture_wr in Capture-DR", {31'd0, capture_wr}, {31'd0, wrap});
        expect_val("R6 shift_wr low in Capture-DR", {31'd0, shift_wr}, 32'd0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
            expect_val("R6 shift_wr in Shift-DR", {31'd0, shift_wr}, {31'd0, wrap});
            expect_val("R8 wsi follows tdi", {31'd0, wsi}, {31'd0, din[i]});
        end
        tick(1, 0, o);
        expect_val("R6 enables low in Exit1-DR", {29'd0, shift_wr, capture_wr, update_wr}, 32'd0);
        tick(0, 0, o);
        expect_val("R6 update_wr in Update-DR", {31'd0, update_wr}, {31'd0, wrap});
        tick(0, 0, o);
        expect_val("R6 enables low in Run-Test/Idle", {29'd0, shift_wr, capture_wr, update_wr}, 32'd0);
    endtask

    // Watchdog
    initial begin
        while (cycles < 100000 && !done) begin
            @(posedge tck);
            cycles++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic        o;
        logic [3:0]  cap;
        logic [31:0] dout;

        // R3 / R2: reset state
        repeat (3) tick(1, 0, o);
        expect_val("R3 wrst_n low under trst_n", {31'd0, wrst_n}, 32'd0);
        expect_val("R5 wrapper lines idle after reset",
                   {28'd0, sel_wir, shift_wr, capture_wr, update_wr}, 32'd0);
        expect_val("R9 tdo_en low after reset", {31'd0, tdo_en}, 32'd0);
        trst_n = 1'b1;
        repeat (2) tick(1, 0, o);
        expect_val("R3 wrst_n low in Test-Logic-Reset", {31'd0, wrst_n}, 32'd0);
        tick(0, 0, o);
        tick(0, 0, o);
        expect_val("R3 wrst_n released in Run-Test/Idle", {31'd0, wrst_n}, 32'd1);
        expect_val("R9 tdo_en low in Run-Test/Idle", {31'd0, tdo_en}, 32'd0);

        // R1: clock copy at both phases
        @(negedge tck); #2;
        expect_val("R1 wrck equals tck low", {31'd0, wrck}, {31'd0, tck});
        @(posedge tck); #2;
        expect_val("R1 wrck equals tck high", {31'd0, wrck}, {31'd0, tck});

        // R5: bypass after reset, pattern 1,1,0,1,0,0,1,0
        dr_scan(8, 32'h4B, 1'b0, dout);
        expect_val("R5 bypass delays tdi by one", dout, 32'h96);

        // R4: capture pattern and undefined code falls back to bypass
        ir_scan(4'b0101, cap);
        expect_val("R4 Capture-IR value 0001", {28'd0, cap}, 32'd1);
        dr_scan(8, 32'h4B, 1'b0, dout);
        expect_val("R4 undefined code acts as bypass", dout, 32'h96);
        expect_val("R7 sel_wir low under bypass", {31'd0, sel_wir}, 32'd0);

        // R7 / R6 / R8: wrapper instruction access, load identity instruction 001
        ir_scan(4'b0010, cap);
        expect_val("R4 Capture-IR value 0001 again", {28'd0, cap}, 32'd1);
        expect_val("R7 sel_wir high under WIR access", {31'd0, sel_wir}, 32'd1);
        dr_scan(3, 32'd1, 1'b1, dout);
        expect_val("R8 wrapper capture bits on tdo", dout, 32'd1);
        expect_val("R6 wrapper took instruction", {29'd0, w_ir}, 32'd1);

        // R10: wrapper data access reads identity
        ir_scan(4'b0011, cap);
        expect_val("R7 sel_wir low under WDR access", {31'd0, sel_wir}, 32'd0);
        dr_scan(32, 32'h0, 1'b1, dout);
        expect_val("R10 identity code read", dout, DIE_ID);

        // R2: five high tms cycles from Run-Test/Idle reach Test-Logic-Reset
        repeat (5) tick(1, 0, o);
        tick(1, 0, o);
        expect_val("R2 five ones reach reset: wrst_n low", {31'd0, wrst_n}, 32'd0);
        expect_val("R2 reset returns bypass: sel_wir low", {31'd0, sel_wir}, 32'd0);
        tick(0, 0, o);
        tick(0, 0, o);
        dr_scan(4, 32'h5, 1'b0, dout);
        expect_val("R2 bypass after tms reset", dout, 32'hA);

        wait (act_q.size() == 0);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule